// File: doc/BRIEF.md
# Front-End Configuration Serial Port

This block sends one configuration or readback command from a module controller to a chain of front-end chips. It does so over a three-wire serial link made of a configuration clock, a load strobe and a serial data line. A 16-bit count word sets the length of each command. It has two fields. The low field is scaled by eight and sets the number of address/command clock pulses. The high field is used as is and sets the number of data clock pulses. The load strobe is low during the address/command pulses and high during the data pulses.

For read-type commands the block also opens a return path. After a fixed number of system clock cycles from the start of the command, it samples the serial readback from the front ends with the system clock and passes it to the controller's return data output. The path stays open until the command ends. For write-type commands the return path stays closed and the return data output stays at 0. A busy flag covers the whole transfer, and any start request that arrives while busy is set is ignored.

Top module: `fe_cfg_port`

## Requirements
- R1: After reset, busy_o, cclk_o, load_o, sdo_o, ret_en_o and ret_data_o are all 0.
- R2: A request is accepted on a rising clock edge where start_i is 1 and busy_o is 0. The transfer then issues N = 8*count_i[2:0] + count_i[15:3] configuration clock pulses. busy_o is 1 for exactly 2*N system cycles after the acceptance edge and 0 in the cycle that follows.
- R3: Each configuration clock pulse is one system cycle low followed by one system cycle high. The first low cycle starts at the acceptance edge, and cclk_o is 0 whenever busy_o is 0.
- R4: load_o is 0 during the first 8*count_i[2:0] pulses and 1 during the remaining count_i[15:3] pulses. It returns to 0 when the transfer ends.
- R5: The address/command pulses carry cmd_i most significant bit first, starting at bit 55.
- R6: The data pulses carry payload_i most significant bit first, starting at bit DATA_W-1, and carry 0 once the payload bits are used up. sdo_o changes only in the cycle in which cclk_o goes low, holds its value while cclk_o is high, and is 0 while idle.
- R7: A field value of 0 skips that phase. If both fields are 0, the request is ignored and busy_o stays 0.
- R8: A start request made while busy_o is 1 has no effect on the transfer in progress.
- R9: For a read request (read_i = 1 at acceptance), ret_en_o is 1 from the 19th system cycle of the transfer until the transfer ends. The cycle that begins at the acceptance edge counts as the first. While the path is open, ret_data_o holds the value of fe_data_i sampled at the rising edge that began the current cycle.
- R10: For a write request (read_i = 0), ret_en_o stays 0 and ret_data_o stays 0. ret_data_o is also 0 whenever ret_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| read_i | input | 1 | 1 = read-type command (opens return path) |
| cmd_i | input | 56 | Address/command bits, sent from bit 55 down |
| payload_i | input | DATA_W | Data payload, sent from the top bit down |
| count_i | input | 16 | [2:0] address/command length in units of 8 pulses, [15:3] data pulse count |
| fe_data_i | input | 1 | Serial readback from the front-end chain |
| cclk_o | output | 1 | Configuration clock |
| load_o | output | 1 | Load strobe, high in the data phase |
| sdo_o | output | 1 | Serial data to the front ends |
| ret_en_o | output | 1 | Return path open |
| ret_data_o | output | 1 | Readback routed to the controller |
| busy_o | output | 1 | Transfer in progress |

## Verification
Random count words mix empty and non-empty address/command fields with data lengths on both sides of the payload width. This shows whether the two fields are weighted correctly and whether the load strobe switches at the right pulse. Read requests are run with transfers shorter than, equal to, and longer than the 19-cycle opening point, which pins down the opening cycle and the closing cycle of the return path. Further directed cases cover the following:
- A zero count word, which checks that the request is dropped.
- A start pulse issued mid-transfer with different operands, which checks that a busy-time request leaves the transfer unchanged.
- The all-ones count word, which checks the longest transfer.

// File: rtl/fe_cfg_pkg.sv
package fe_cfg_pkg;
  localparam int CNT_W      = 16;
  localparam int AC_FIELD_W = 3;
  localparam int AC_SCALE   = 8;
  localparam int DL_W       = CNT_W - AC_FIELD_W;
  localparam int ACMD_W     = ((1 << AC_FIELD_W) - 1) * AC_SCALE;
  localparam int AC_LEFT_W  = $clog2(ACMD_W + 1);
  localparam int RET_IDX    = 19;
endpackage

// File: rtl/fe_cfg_seq.sv
module fe_cfg_seq
  import fe_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             accept_o,
  output logic             adv_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             cclk_o,
  output logic             load_o
);
  logic [AC_LEFT_W-1:0] ac_left_q;
  logic [DL_W-1:0]      dat_left_q;
  logic [AC_FIELD_W-1:0] ac_f;
  logic [DL_W-1:0]       dl_f;
  logic                  last;

  assign ac_f     = count_i[AC_FIELD_W-1:0];
  assign dl_f     = count_i[CNT_W-1:AC_FIELD_W];
  assign accept_o = start_i && !busy_o && (ac_f != '0 || dl_f != '0);
  assign last     = (ac_left_q == AC_LEFT_W'(1) && dat_left_q == '0) ||
                    (ac_left_q == '0 && dat_left_q == DL_W'(1));
  assign adv_o    = busy_o && cclk_o && !last;
  assign done_o   = busy_o && cclk_o && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cclk_o     <= 1'b0;
      load_o     <= 1'b0;
      ac_left_q  <= '0;
      dat_left_q <= '0;
    end else if (accept_o) begin
      busy_o     <= 1'b1;
      cclk_o     <= 1'b0;
      load_o     <= (ac_f == '0);
      ac_left_q  <= AC_LEFT_W'(ac_f) * AC_LEFT_W'(AC_SCALE);
      dat_left_q <= dl_f;
    end else if (busy_o) begin
      if (!cclk_o) begin
        cclk_o <= 1'b1;
      end else begin
        cclk_o <= 1'b0;
        if (ac_left_q != '0) ac_left_q  <= ac_left_q - AC_LEFT_W'(1);
        else                 dat_left_q <= dat_left_q - DL_W'(1);
        if (last) begin
          busy_o <= 1'b0;
          load_o <= 1'b0;
        end else begin
          // data phase begins once the last acmd pulse is consumed
          load_o <= (ac_left_q <= AC_LEFT_W'(1));
        end
      end
    end
  end
endmodule

// File: rtl/fe_cfg_shift.sv
module fe_cfg_shift
  import fe_cfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              adv_i,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [ACMD_W-1:0] cmd_i,
  input  logic [DATA_W-1:0] payload_i,
  output logic              sdo_o
);
  logic [ACMD_W-1:0] cmd_sh_q;
  logic [DATA_W-1:0] dat_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_sh_q <= '0;
      dat_sh_q <= '0;
    end else if (accept_i) begin
      cmd_sh_q <= cmd_i;
      dat_sh_q <= payload_i;
    end else if (adv_i) begin
      // shift the source of the pulse just finished
      if (load_i) dat_sh_q <= {dat_sh_q[DATA_W-2:0], 1'b0};
      else        cmd_sh_q <= {cmd_sh_q[ACMD_W-2:0], 1'b0};
    end
  end

  assign sdo_o = busy_i && (load_i ? dat_sh_q[DATA_W-1] : cmd_sh_q[ACMD_W-1]);
endmodule

// File: rtl/fe_cfg_ret.sv
module fe_cfg_ret
  import fe_cfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic done_i,
  input  logic busy_i,
  input  logic read_i,
  input  logic fe_data_i,
  output logic ret_en_o,
  output logic ret_data_o
);
  localparam int RC_W = $clog2(RET_IDX + 1);
  localparam logic [RC_W-1:0] OPEN_AT = RC_W'(RET_IDX - 1);

  logic [RC_W-1:0] cyc_q;
  logic            rd_q;
  logic            en_d;

  always_comb begin
    en_d = ret_en_o;
    if (accept_i)    en_d = 1'b0;
    else if (done_i) en_d = 1'b0;
    else if (busy_i && rd_q && cyc_q == OPEN_AT) en_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q      <= '0;
      rd_q       <= 1'b0;
      ret_en_o   <= 1'b0;
      ret_data_o <= 1'b0;
    end else begin
      ret_en_o   <= en_d;
      ret_data_o <= en_d && fe_data_i;
      if (accept_i) begin
        cyc_q <= RC_W'(1);
        rd_q  <= read_i;
      end else if (busy_i && cyc_q != OPEN_AT) begin
        cyc_q <= cyc_q + RC_W'(1);
      end
    end
  end
endmodule

// File: rtl/fe_cfg_port.sv
module fe_cfg_port
  import fe_cfg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [ACMD_W-1:0] cmd_i,
  input  logic [DATA_W-1:0] payload_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              fe_data_i,
  output logic              cclk_o,
  output logic              load_o,
  output logic              sdo_o,
  output logic              ret_en_o,
  output logic              ret_data_o,
  output logic              busy_o
);
  logic accept, adv, done;

  fe_cfg_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .count_i  (count_i),
    .accept_o (accept),
    .adv_o    (adv),
    .done_o   (done),
    .busy_o   (busy_o),
    .cclk_o   (cclk_o),
    .load_o   (load_o)
  );

  fe_cfg_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .adv_i     (adv),
    .busy_i    (busy_o),
    .load_i    (load_o),
    .cmd_i     (cmd_i),
    .payload_i (payload_i),
    .sdo_o     (sdo_o)
  );

  fe_cfg_ret u_ret (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .done_i     (done),
    .busy_i     (busy_o),
    .read_i     (read_i),
    .fe_data_i  (fe_data_i),
    .ret_en_o   (ret_en_o),
    .ret_data_o (ret_data_o)
  );
endmodule

// File: rtl/fe_cfg_port_chk.sv
module fe_cfg_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cclk_o,
  input logic load_o,
  input logic sdo_o,
  input logic ret_en_o,
  input logic ret_data_o,
  input logic busy_o
);
  // R3
  cclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cclk_o);
  // R3
  cclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |=> !cclk_o);
  // R4
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> busy_o);
  // R4
  load_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(load_o) |-> !busy_o);
  // R6
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |-> $stable(sdo_o) && $stable(load_o));
  // R6
  sdo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sdo_o);
  // R9
  ret_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_en_o |-> busy_o);
  // R10
  ret_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_en_o |-> !ret_data_o);
endmodule

bind fe_cfg_port fe_cfg_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cclk_o     (cclk_o),
  .load_o     (load_o),
  .sdo_o      (sdo_o),
  .ret_en_o   (ret_en_o),
  .ret_data_o (ret_data_o),
  .busy_o     (busy_o)
);

// File: tb/fe_cfg_port_test.sv
module fe_cfg_port_test;
  localparam int DATA_W = 16;
  localparam int CW     = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0, fe = 1'b0;
  logic [CW-1:0] cmd = '0;
  logic [DATA_W-1:0] pay = '0;
  logic [15:0] cnt = '0;
  logic cclk, load, sdo, ret_en, ret_data, busy;

  int n_chk = 0, n_bad = 0;
  bit done_run = 0;

  always #5 clk = ~clk;

  fe_cfg_port #(.DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .read_i(rd),
    .cmd_i(cmd), .payload_i(pay), .count_i(cnt), .fe_data_i(fe),
    .cclk_o(cclk), .load_o(load), .sdo_o(sdo), .ret_en_o(ret_en),
    .ret_data_o(ret_data), .busy_o(busy)
  );

  task automatic chk(string req, string what, logic act, logic exp, int cyc);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic exp_bit(logic [CW-1:0] c, logic [DATA_W-1:0] p, int a, int j);
    if (j < a) return c[CW-1-j];
    if (j - a < DATA_W) return p[DATA_W-1-(j-a)];
    return 1'b0;
  endfunction

  // run one accepted transfer; optionally raise start mid-transfer (R8)
  task automatic run_txn(logic r, logic [CW-1:0] c, logic [DATA_W-1:0] p,
                         logic [15:0] w, bit interfere);
    int a, n;
    logic fe_cur;
    a = 8 * int'(w[2:0]);
    n = a + int'(w[15:3]);
    @(negedge clk);
    start = 1'b1; rd = r; cmd = c; pay = p; cnt = w;
    fe_cur = 1'($urandom); fe = fe_cur;
    for (int m = 0; m <= 2 * n; m++) begin
      bit open;
      @(negedge clk);
      open = r && m >= 18 && m < 2 * n;
      if (m < 2 * n) begin
        chk("R2", "busy", busy, 1'b1, m);
        chk("R3", "cclk", cclk, 1'(m % 2), m);
        chk("R4", "load", load, (m / 2) >= a, m);
        chk((m / 2) < a ? "R5" : "R6", "sdo", sdo, exp_bit(c, p, a, m / 2), m);
      end else begin
        chk("R2", "busy end", busy, 1'b0, m);
        chk("R3", "cclk end", cclk, 1'b0, m);
        chk("R4", "load end", load, 1'b0, m);
        chk("R6", "sdo end", sdo, 1'b0, m);
      end
      chk(r ? "R9" : "R10", "ret_en", ret_en, open, m);
      chk(r ? "R9" : "R10", "ret_data", ret_data, open ? fe_cur : 1'b0, m);
      fe_cur = 1'($urandom); fe = fe_cur;
      if (interfere && m == 3) begin
        // R8: conflicting request while busy
        start = 1'b1; rd = ~r; cmd = ~c; pay = ~p; cnt = 16'hFFFF;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20251);
    #1;
    // R1 reset state
    chk("R1", "busy", busy, 1'b0, 0);
    chk("R1", "cclk", cclk, 1'b0, 0);
    chk("R1", "load", load, 1'b0, 0);
    chk("R1", "sdo", sdo, 1'b0, 0);
    chk("R1", "ret_en", ret_en, 1'b0, 0);
    chk("R1", "ret_data", ret_data, 1'b0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2/R5/R6 directed: 8 acmd pulses, 1 data pulse
    run_txn(1'b0, 56'hA5_0000_0000_0000, 16'h8000, 16'h0009, 0);
    // R7: acmd field zero
    run_txn(1'b0, 56'hFF_FFFF_FFFF_FFFF, 16'hC3A5, 16'h0050, 0);
    // R7: data field zero
    run_txn(1'b1, 56'h12_3456_789A_BCDE, 16'hFFFF, 16'h0003, 0);
    // R9: read shorter than opening point (9 pulses = 18 cycles)
    run_txn(1'b1, 56'h00_0000_0000_0001, 16'h1234, 16'h0009, 0);
    // R9: read, opens at cycle 18 and data beyond payload width (R6)
    run_txn(1'b1, 56'hDE_ADBE_EF01_2345, 16'hBEEF, 16'h00A2, 0);
    // R8: start while busy
    run_txn(1'b0, 56'h3C_3C3C_3C3C_3C3C, 16'h5A5A, 16'h0061, 1);
    run_txn(1'b1, 56'h81_8181_8181_8181, 16'h0F0F, 16'h0102, 1);

    // R7: both fields zero, request dropped
    @(negedge clk);
    start = 1'b1; cnt = 16'h0000; rd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R7", "busy zero count", busy, 1'b0, i);
      chk("R7", "cclk zero count", cclk, 1'b0, i);
    end

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [15:0] w;
      w = {13'($urandom % 40), 3'($urandom)};
      if (w == 16'h0) w = 16'h0008;
      run_txn(1'($urandom), {24'($urandom), 32'($urandom)}, 16'($urandom), w,
              (t % 5) == 0);
    end

    // longest transfer
    run_txn(1'b1, {24'($urandom), 32'($urandom)}, 16'($urandom), 16'hFFFF, 1);

    done_run = 1;
  end

  initial begin
    fork
      wait (done_run);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule